// File: doc/BRIEF.md
# Effective Address Quadrant Qualifier

This unit sits in front of a radix translation walker. It accepts one request at a time: a 64-bit effective address, an instruction-fetch flag, the hypervisor-mode flag and the relocation-enable flag. The current partition ID, process ID and real-mode offset configuration are sampled alongside the request. The top two address bits select one of four quadrants. The unit turns each request into one of three results: a fully qualified (partition, process) identifier pair, a segment fault, or a direct physical address for hypervisor real mode.

The hypervisor may use all four quadrants. A guest may use only quadrants 0 and 3. The ten address bits just below the quadrant field must be zero on every translated path. A segment fault is classed as an instruction fault for fetches and as a data fault for loads and stores. A data fault also latches the faulting address.

Each result is registered and is presented one cycle after acceptance. It is held until the consumer acknowledges it. A new request is taken only while no result is pending.

Top module: `ea_quadrant_qualifier`

## Requirements
- R1: `req_ready` is high exactly when no result is pending. A request accepted at a clock edge (`req_valid` and `req_ready` both high) raises `rsp_valid` at that edge. All result fields then stay stable until an edge at which `rsp_ack` is high, and `rsp_valid` falls at that edge. A request presented while a result is pending is ignored. After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: On any path other than hypervisor real mode, a nonzero value in address bits 61..52 gives a segment fault, whatever the quadrant.
- R3: With `req_hv`=1 and `req_reloc`=1, quadrant `req_ea[63:62]` maps as follows: 0 gives partition 0 with the configured process ID; 1 gives the configured partition with the configured process ID; 2 gives the configured partition with process 0; 3 gives partition 0 with process 0.
- R4: With `req_hv`=0, whatever the value of `req_reloc`, quadrant 0 gives the configured partition with the configured process ID. Quadrant 3 gives the configured partition with process 0.
- R5: With `req_hv`=0, quadrants 1 and 2 give a segment fault.
- R6: `rsp_fault_kind` encodes the result: 0 means no fault, 1 means an instruction segment fault (`req_fetch`=1), and 2 means a data segment fault (`req_fetch`=0). The value 3 never appears.
- R7: `rsp_fault_addr` takes the request address on every accepted data segment fault. It keeps its value on every other result, including instruction segment faults, and resets to 0.
- R8: With `req_hv`=1 and `req_reloc`=0 the result is real mode (`rsp_real`=1). `rsp_paddr` is the address with bits 63..60 cleared. The configured offset is ORed in only when address bit 63 is 0.
- R9: A real-mode result never faults, even when bits 61..52 are nonzero. It reports `rsp_perm`=3'b111 (bit 2 read, bit 1 write, bit 0 execute) and partition and process 0.
- R10: A result that is not real mode reports `rsp_paddr`=0 and `rsp_perm`=0. A faulted result also reports partition 0 and process 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | No result pending; request can be taken |
| req_ea | input | 64 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = load or store |
| req_hv | input | 1 | Hypervisor mode |
| req_reloc | input | 1 | Relocation enabled |
| cfg_part_id | input | 12 | Configured partition ID |
| cfg_proc_id | input | 20 | Configured process ID |
| cfg_rm_offset | input | 64 | Real-mode offset |
| rsp_valid | output | 1 | Result pending |
| rsp_ack | input | 1 | Consumer takes the result |
| rsp_fault_kind | output | 2 | 0 none, 1 instruction segment, 2 data segment |
| rsp_fault_addr | output | 64 | Last data-fault address |
| rsp_real | output | 1 | Result is real mode |
| rsp_part_id | output | 12 | Qualified partition ID |
| rsp_proc_id | output | 20 | Qualified process ID |
| rsp_paddr | output | 64 | Real-mode physical address |
| rsp_perm | output | 3 | Read/write/execute grant |

## Verification
The only stored state is the pending-result flag, the result fields and the latched fault address. A wrong pending flag shows at once as a mismatch between `req_ready` and `rsp_valid`, or as a request that was dropped or taken twice. A wrong fault-address register stays hidden through any number of good translations and instruction faults. It is exposed because that port is compared on every cycle. A decode slip in one quadrant or mode shows in the very result that exercises it, one cycle after acceptance. The bench therefore covers all four quadrants in each privilege mode, both fault classes, and both polarities of address bit 63.

// File: rtl/eaq_pkg.sv
// Package: shared result encodings for the quadrant qualifier.
// Assumes a two-bit quadrant field at the top of the effective address.
package eaq_pkg;
    localparam int QUAD_W = 2;

    typedef enum logic [1:0] {
        FK_NONE     = 2'd0,
        FK_INST_SEG = 2'd1,
        FK_DATA_SEG = 2'd2
    } fault_kind_e;

    localparam logic [2:0] PERM_ALL  = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/eaq_quadrant_map.sv
// Module: eaq_quadrant_map
// Decodes the top address field into a (partition, process) pair, or
// flags the request as illegal. Purely combinational. Assumes the caller
// passes only the quadrant bits and the must-be-zero bits below them.
module eaq_quadrant_map
    import eaq_pkg::*;
#(
    parameter int CHK_W  = 10,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [QUAD_W+CHK_W-1:0] ea_top,
    input  logic                    hv,
    input  logic [LPID_W-1:0]       cfg_lpid,
    input  logic [PID_W-1:0]        cfg_pid,
    output logic                    legal,
    output logic [LPID_W-1:0]       lpid_o,
    output logic [PID_W-1:0]        pid_o
);
    localparam int TOP_W = QUAD_W + CHK_W;

    logic [QUAD_W-1:0] quad;
    logic              range_ok;

    // Split the field into quadrant and must-be-zero guard bits.
    always_comb begin
        quad     = ea_top[TOP_W-1 -: QUAD_W];
        range_ok = ~|ea_top[CHK_W-1:0];
    end

    // Select identifiers per privilege mode and quadrant.
    always_comb begin
        legal  = range_ok;
        lpid_o = '0;
        pid_o  = '0;
        if (hv) begin
            unique case (quad)
                2'd0: begin lpid_o = '0;       pid_o = cfg_pid; end
                2'd1: begin lpid_o = cfg_lpid; pid_o = cfg_pid; end
                2'd2: begin lpid_o = cfg_lpid; pid_o = '0;      end
                default: begin lpid_o = '0;    pid_o = '0;      end
            endcase
        end else begin
            unique case (quad)
                2'd0: begin lpid_o = cfg_lpid; pid_o = cfg_pid; end
                2'd3: begin lpid_o = cfg_lpid; pid_o = '0;      end
                default: legal = 1'b0;
            endcase
        end
        if (!legal) begin
            lpid_o = '0;
            pid_o  = '0;
        end
    end
endmodule

// File: rtl/eaq_real_path.sv
// Module: eaq_real_path
// Forms the hypervisor real-mode physical address. It clears the top
// CLR_W bits and merges the offset when the top address bit is clear.
// Combinational; CLR_W may be zero.
module eaq_real_path #(
    parameter int EA_W  = 64,
    parameter int CLR_W = 4
) (
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] rm_offset,
    output logic [EA_W-1:0] paddr
);
    logic [EA_W-1:0] kept;

    generate
        if (CLR_W == 0) begin : g_noclr
            // No top bits are dropped.
            always_comb kept = ea;
        end else begin : g_clr
            localparam logic [EA_W-1:0] KEEP_MASK =
                {{CLR_W{1'b0}}, {(EA_W-CLR_W){1'b1}}};
            // Drop the ignored top bits.
            always_comb kept = ea & KEEP_MASK;
        end
    endgenerate

    // Merge the offset only for addresses with the top bit clear.
    always_comb paddr = kept | (ea[EA_W-1] ? '0 : rm_offset);
endmodule

// File: rtl/eaq_rsp_stage.sv
// Module: eaq_rsp_stage
// Single-entry result register with a valid/acknowledge handshake and a
// sticky data-fault address register. Assumes load is only raised while
// ready is high.
module eaq_rsp_stage
    import eaq_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ack,
    input  logic [1:0]        n_kind,
    input  logic              n_real,
    input  logic [LPID_W-1:0] n_lpid,
    input  logic [PID_W-1:0]  n_pid,
    input  logic [EA_W-1:0]   n_paddr,
    input  logic [2:0]        n_perm,
    input  logic [EA_W-1:0]   n_ea,
    output logic              ready,
    output logic              valid,
    output logic [1:0]        kind,
    output logic              real_mode,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid,
    output logic [EA_W-1:0]   paddr,
    output logic [2:0]        perm,
    output logic [EA_W-1:0]   fault_addr
);
    // Accept only when nothing is pending.
    always_comb ready = ~valid;

    // Pending flag: set on load, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        valid <= 1'b0;
        else if (load)     valid <= 1'b1;
        else if (ack)      valid <= 1'b0;
    end

    // Result fields captured on load and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind      <= FK_NONE;
            real_mode <= 1'b0;
            lpid      <= '0;
            pid       <= '0;
            paddr     <= '0;
            perm      <= PERM_NONE;
        end else if (load) begin
            kind      <= n_kind;
            real_mode <= n_real;
            lpid      <= n_lpid;
            pid       <= n_pid;
            paddr     <= n_paddr;
            perm      <= n_perm;
        end
    end

    // Fault address captured only on data segment faults.
    always_ff @(posedge clk) begin
        if (!rst_n)                              fault_addr <= '0;
        else if (load && n_kind == FK_DATA_SEG)  fault_addr <= n_ea;
    end

    AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid); // R1
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> (valid && $stable({kind, real_mode, lpid, pid, paddr, perm}))); // R1
    AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack) |=> !valid); // R1
    AST_KIND_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (kind != 2'd3)); // R6
    AST_FADDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && n_kind == FK_DATA_SEG) |=> $stable(fault_addr)); // R7
endmodule

// File: rtl/ea_quadrant_qualifier.sv
// Module: ea_quadrant_qualifier (top)
// Qualifies an effective address into partition/process identifiers.
// Otherwise it reports a segment fault, or forms a real-mode physical
// address. One result is in flight at a time; it is registered and held
// until acknowledged. Configuration inputs are sampled at acceptance.
module ea_quadrant_qualifier
    import eaq_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int CHK_W  = 10,
    parameter int CLR_W  = 4,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_fetch,
    input  logic              req_hv,
    input  logic              req_reloc,
    input  logic [LPID_W-1:0] cfg_part_id,
    input  logic [PID_W-1:0]  cfg_proc_id,
    input  logic [EA_W-1:0]   cfg_rm_offset,
    output logic              rsp_valid,
    input  logic              rsp_ack,
    output logic [1:0]        rsp_fault_kind,
    output logic [EA_W-1:0]   rsp_fault_addr,
    output logic              rsp_real,
    output logic [LPID_W-1:0] rsp_part_id,
    output logic [PID_W-1:0]  rsp_proc_id,
    output logic [EA_W-1:0]   rsp_paddr,
    output logic [2:0]        rsp_perm
);
    localparam int TOP_W  = QUAD_W + CHK_W;
    localparam int CHK_HI = EA_W - 1 - QUAD_W;

    logic              accept;
    logic              real_sel;
    logic              map_legal;
    logic [LPID_W-1:0] map_lpid;
    logic [PID_W-1:0]  map_pid;
    logic [EA_W-1:0]   real_paddr;
    fault_kind_e       kind_n;
    logic [LPID_W-1:0] lpid_n;
    logic [PID_W-1:0]  pid_n;
    logic [EA_W-1:0]   paddr_n;
    logic [2:0]        perm_n;

    eaq_quadrant_map #(
        .CHK_W (CHK_W),
        .LPID_W(LPID_W),
        .PID_W (PID_W)
    ) map_i (
        .ea_top  (req_ea[EA_W-1 -: TOP_W]),
        .hv      (req_hv),
        .cfg_lpid(cfg_part_id),
        .cfg_pid (cfg_proc_id),
        .legal   (map_legal),
        .lpid_o  (map_lpid),
        .pid_o   (map_pid)
    );

    eaq_real_path #(
        .EA_W (EA_W),
        .CLR_W(CLR_W)
    ) real_i (
        .ea       (req_ea),
        .rm_offset(cfg_rm_offset),
        .paddr    (real_paddr)
    );

    // Handshake and path selection.
    always_comb begin
        accept   = req_valid & req_ready;
        real_sel = req_hv & ~req_reloc;
    end

    // Merge the two paths into the next result.
    always_comb begin
        kind_n  = FK_NONE;
        lpid_n  = '0;
        pid_n   = '0;
        paddr_n = '0;
        perm_n  = PERM_NONE;
        if (real_sel) begin
            paddr_n = real_paddr;
            perm_n  = PERM_ALL;
        end else if (!map_legal) begin
            kind_n = req_fetch ? FK_INST_SEG : FK_DATA_SEG;
        end else begin
            lpid_n = map_lpid;
            pid_n  = map_pid;
        end
    end

    eaq_rsp_stage #(
        .EA_W  (EA_W),
        .LPID_W(LPID_W),
        .PID_W (PID_W)
    ) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .ack       (rsp_ack),
        .n_kind    (kind_n),
        .n_real    (real_sel),
        .n_lpid    (lpid_n),
        .n_pid     (pid_n),
        .n_paddr   (paddr_n),
        .n_perm    (perm_n),
        .n_ea      (req_ea),
        .ready     (req_ready),
        .valid     (rsp_valid),
        .kind      (rsp_fault_kind),
        .real_mode (rsp_real),
        .lpid      (rsp_part_id),
        .pid       (rsp_proc_id),
        .paddr     (rsp_paddr),
        .perm      (rsp_perm),
        .fault_addr(rsp_fault_addr)
    );

    AST_GUARD_BITS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(req_hv && !req_reloc) && (|req_ea[CHK_HI -: CHK_W]))
        |=> (rsp_fault_kind != 2'd0)); // R2
    AST_GUEST_MID_QUAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_hv && (req_ea[EA_W-1] ^ req_ea[EA_W-2]))
        |=> (rsp_fault_kind != 2'd0)); // R5
    AST_REAL_GRANTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_hv && !req_reloc)
        |=> (rsp_real && rsp_fault_kind == 2'd0 && rsp_perm == 3'b111)); // R9
    AST_VIRT_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_real) |-> (rsp_paddr == '0 && rsp_perm == 3'b000)); // R10
endmodule

// File: tb/ea_quadrant_qualifier_tb.sv
`timescale 1ns/1ps
module ea_quadrant_qualifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic        req_fetch = 1'b0;
    logic        req_hv = 1'b0;
    logic        req_reloc = 1'b0;
    logic [11:0] cfg_part_id = 12'hA5C;
    logic [19:0] cfg_proc_id = 20'h31D7E;
    logic [63:0] cfg_rm_offset = 64'h0000_0123_4000_0000;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic [1:0]  rsp_fault_kind;
    logic [63:0] rsp_fault_addr;
    logic        rsp_real;
    logic [11:0] rsp_part_id;
    logic [19:0] rsp_proc_id;
    logic [63:0] rsp_paddr;
    logic [2:0]  rsp_perm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ea_quadrant_qualifier dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
        .req_fetch(req_fetch), .req_hv(req_hv), .req_reloc(req_reloc),
        .cfg_part_id(cfg_part_id), .cfg_proc_id(cfg_proc_id),
        .cfg_rm_offset(cfg_rm_offset),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_fault_kind(rsp_fault_kind), .rsp_fault_addr(rsp_fault_addr),
        .rsp_real(rsp_real), .rsp_part_id(rsp_part_id),
        .rsp_proc_id(rsp_proc_id), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
    );

    always #4 clk = ~clk; // 125 MHz

    // Reference model state (state after the most recent clock edge).
    bit          m_valid = 0;
    logic [1:0]  m_kind = 0;
    bit          m_real = 0;
    logic [11:0] m_lpid = 0;
    logic [19:0] m_pid = 0;
    logic [63:0] m_paddr = 0;
    logic [2:0]  m_perm = 0;
    logic [63:0] m_faddr = 0;
    string       m_tag = "R1";

    // Behavioural reference: derive the expected result from the rules.
    task automatic model_result(input logic [63:0] ea, input bit f, h, r);
        bit bad = 0;
        m_kind = 0; m_real = 0; m_lpid = 0; m_pid = 0; m_paddr = 0; m_perm = 0;
        if (h && !r) begin
            m_real  = 1;
            m_perm  = 3'b111;
            m_paddr = {4'h0, ea[59:0]};
            if (ea[63] == 1'b0) m_paddr = m_paddr | cfg_rm_offset;
            m_tag = "R8/R9";
        end else if (ea[61:52] != 10'd0) begin
            bad = 1; m_tag = "R2/R6";
        end else if (h) begin
            m_tag = "R3";
            if (ea[63:62] == 2'd1 || ea[63:62] == 2'd2) m_lpid = cfg_part_id;
            if (ea[63:62] == 2'd0 || ea[63:62] == 2'd1) m_pid  = cfg_proc_id;
        end else if (ea[63:62] == 2'd0) begin
            m_tag = "R4"; m_lpid = cfg_part_id; m_pid = cfg_proc_id;
        end else if (ea[63:62] == 2'd3) begin
            m_tag = "R4"; m_lpid = cfg_part_id;
        end else begin
            bad = 1; m_tag = "R5/R6";
        end
        if (bad) begin
            m_kind = f ? 2'd1 : 2'd2;
            if (!f) m_faddr = ea;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_kind = 0; m_real = 0; m_lpid = 0; m_pid = 0;
            m_paddr = 0; m_perm = 0; m_faddr = 0; m_tag = "R1";
        end else if (req_valid && !m_valid) begin
            model_result(req_ea, req_fetch, req_hv, req_reloc);
            m_valid = 1;
        end else if (m_valid && rsp_ack) begin
            m_valid = 0;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, half a period after the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "req_ready", {63'd0, req_ready}, {63'd0, !m_valid});
            chk("R1", "rsp_valid", {63'd0, rsp_valid}, {63'd0, m_valid});
            chk("R7", "rsp_fault_addr", rsp_fault_addr, m_faddr);
            if (m_valid) begin
                chk(m_tag, "rsp_fault_kind", {62'd0, rsp_fault_kind}, {62'd0, m_kind});
                chk(m_tag, "rsp_real", {63'd0, rsp_real}, {63'd0, m_real});
                chk(m_tag, "rsp_part_id", {52'd0, rsp_part_id}, {52'd0, m_lpid});
                chk(m_tag, "rsp_proc_id", {44'd0, rsp_proc_id}, {44'd0, m_pid});
                chk({m_tag, "/R10"}, "rsp_paddr", rsp_paddr, m_paddr);
                chk({m_tag, "/R10"}, "rsp_perm", {61'd0, rsp_perm}, {61'd0, m_perm});
            end
        end
    end

    // One request; optionally a second one presented while pending (R1).
    task automatic send(input logic [63:0] ea, input bit f, h, r,
                        input int hold, input bit overlap);
        @(posedge clk); #1;
        req_ea = ea; req_fetch = f; req_hv = h; req_reloc = r; req_valid = 1;
        @(posedge clk); #1;
        req_valid = 0;
        if (overlap) begin
            req_ea = ~ea; req_fetch = ~f; req_valid = 1;
        end
        repeat (hold) @(posedge clk);
        #1 rsp_ack = 1;
        @(posedge clk); #1;
        rsp_ack = 0; req_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state checked by the per-cycle compare from here on.
        repeat (2) @(posedge clk);
        // R3: hypervisor, relocation on, all quadrants.
        send(64'h0000_0000_0000_1234, 0, 1, 1, 0, 0);
        send(64'h4000_0000_000A_BCDE, 0, 1, 1, 2, 0);
        send(64'h8000_0000_0000_0040, 1, 1, 1, 1, 0);
        send(64'hC000_000F_FFFF_FFFF, 0, 1, 1, 0, 0);
        // R4: guest quadrants 0 and 3, relocation on and off.
        send(64'h000F_FFFF_FFFF_FFF8, 0, 0, 1, 0, 0);
        send(64'hC000_0000_1111_0000, 1, 0, 1, 0, 0);
        send(64'h0000_0000_2222_0000, 0, 0, 0, 1, 0);
        // R5 R6 R7: guest illegal quadrants, data then fetch.
        send(64'h4000_0000_DEAD_0000, 0, 0, 1, 0, 0);
        send(64'h8000_0000_BEEF_0000, 1, 0, 1, 0, 0);
        send(64'h8000_0000_0000_7770, 0, 0, 0, 0, 0);
        // R2: guard bits, edge positions, several modes.
        send(64'h0010_0000_0000_0000, 0, 1, 1, 0, 0);
        send(64'hC000_0000_0000_0000 | 64'h2000_0000_0000_0000, 1, 0, 1, 0, 0);
        send(64'h3FF0_0000_0000_0100, 0, 0, 1, 0, 0);
        // R8 R9: real mode, bit 63 clear and set, guard bits nonzero.
        send(64'h7FFF_FFFF_FFFF_FFFF, 0, 1, 0, 0, 0);
        send(64'hF234_5678_9ABC_DEF0, 1, 1, 0, 0, 0);
        send(64'h0010_0000_0000_0008, 0, 1, 0, 0, 0);
        // R1: request presented while a result is pending is ignored.
        send(64'h4000_0000_0000_5550, 0, 1, 1, 3, 1);
        send(64'h4000_0000_0000_6660, 0, 0, 1, 2, 1);
        // R3 R4 R10: new configuration values.
        @(posedge clk); #1;
        cfg_part_id = 12'h001; cfg_proc_id = 20'hFFFFF; cfg_rm_offset = '1;
        send(64'h4000_0000_0000_0000, 0, 1, 1, 0, 0);
        send(64'h0000_0000_0000_0000, 1, 0, 1, 0, 0);
        send(64'h0FFF_0000_0000_0000, 0, 1, 0, 0, 0);
        // R7: instruction fault leaves last data fault address.
        send(64'h8000_0000_0000_0001, 1, 0, 1, 0, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule